// File: doc/BRIEF.md
# Page-Erase Write Sequencer for a Byte-Programmable Non-Volatile Array

This block accepts register-style byte reads and writes and drives a page-organised non-volatile array held inside it as a behavioural model. A cell can only drop bits from 1 to 0 when it is programmed. Only a page-wide erase brings bits back to 1, and an erased byte reads 8'hFF. A write first looks at the target byte. If it reads 8'hFF, the controller programs it straight away. Otherwise the controller erases the whole page, checks that every byte of the page reads 8'hFF, programs the byte, and then checks that the byte reads back as the written value. The other bytes of an erased page are not restored.

Erase and program each take a number of clock cycles set by a parameter, so a write keeps `busy` high for many cycles. Reads are served only while the controller is idle. A request that arrives while the controller is busy is dropped and sets a sticky overrun flag. Each page has a counter of finished write sequences, which can be read through a select port. Once a page's counter reaches the endurance parameter, the page is worn out and its cells no longer respond to erase or program. This is how the error paths show up.

Top module: `nvm_seq`

## Requirements
- R1: After reset, busy, done, rd_valid, erase_err, prog_err and overrun are 0, every byte reads 8'hFF, and every page counter reads 0.
- R2: A read request accepted while idle gives rd_valid high for exactly the next cycle, with rd_data holding the addressed byte.
- R3: A write whose target byte reads 8'hFF skips the erase. Busy stays high for PROG_CYC+3 cycles, the byte then reads the written value, and the other bytes of the page are unchanged.
- R4: A write whose target byte is not 8'hFF erases the whole page, verifies it, programs and verifies. Busy lasts ERASE_CYC+PAGE_BYTES+PROG_CYC+3 cycles. Afterwards the other bytes of that page read 8'hFF, and the other pages are unchanged.
- R5: done is high for exactly one cycle per write, in the last cycle of busy.
- R6: A byte is programmed only while it reads 8'hFF.
- R7: If any byte of the page reads other than 8'hFF after the erase, erase_err is set and the sequence ends without programming. Busy lasts ERASE_CYC+PAGE_BYTES+2 cycles.
- R8: If the programmed byte does not read back as the written value, prog_err is set.
- R9: A read or write request that arrives while busy is ignored, and it sets overrun. overrun stays 1 until reset.
- R10: Every write sequence that ends, with or without an error, adds 1 to its page's counter (saturating). The counter is read as cnt_value for the page given on cnt_page.
- R11: A page whose counter is at least ENDURANCE is worn. Its cells keep their contents through erase and program.
- R12: erase_err and prog_err are cleared when the next write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; upper bits select the page |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle |
| rd_data | output | 8 | Read data |
| busy | output | 1 | Write sequence in progress |
| done | output | 1 | Final cycle of a write sequence |
| erase_err | output | 1 | Erase verify failed on the last write |
| prog_err | output | 1 | Program verify failed on the last write |
| overrun | output | 1 | Sticky: a request arrived while busy |
| cnt_page | input | ADDR_W-PAGE_W | Page whose write counter is shown |
| cnt_value | output | CNT_W | Write counter of the selected page |

## Verification
Writes are tried on blank bytes, on bytes that already hold data, with the all-ones value, and with the all-zero value. These patterns separate the skip path from the full erase path, both by the busy length and by the state of the neighbouring bytes. A page is driven past its endurance so that a non-blank target gives the erase-failure path and a blank target gives the program-failure path. Running these two back to back also shows that the flags clear on the next write. Requests injected in the middle of a write show that neither the array nor the read port is touched, and that overrun stays set.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_CHECK,
      S_ERASE,
      S_VFYE,
      S_PROG,
      S_VFYP,
      S_DONE
   } seq_state_t;

   localparam logic [7:0] BLANK = 8'hFF;
endpackage

// File: rtl/nvm_timer.sv
module nvm_timer #(
   parameter int TW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expire
);
   logic [TW-1:0] cnt;
   logic          active;

   assign expire = active && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         active <= 1'b0;
      end else if (load) begin
         cnt    <= load_val;
         active <= 1'b1;
      end else if (expire) begin
         active <= 1'b0;
      end else if (active) begin
         cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/nvm_array.sv
module nvm_array
   import nvm_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int PAGE_W = 4,
   localparam int DEPTH      = 1 << ADDR_W,
   localparam int PAGE_BYTES = 1 << PAGE_W,
   localparam int PI_W       = ADDR_W - PAGE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_byte,
   input  logic              erase_en,
   input  logic [PI_W-1:0]   erase_page,
   input  logic              prog_en,
   input  logic [ADDR_W-1:0] prog_addr,
   input  logic [7:0]        prog_data
);
   logic [7:0] mem [DEPTH];

   assign rd_byte = mem[rd_addr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= BLANK;
      end else if (erase_en) begin
         for (int j = 0; j < PAGE_BYTES; j++)
            mem[{erase_page, PAGE_W'(j)}] <= BLANK;
      end else if (prog_en) begin
         // cells can only be pulled from 1 to 0
         mem[prog_addr] <= mem[prog_addr] & prog_data;
      end
   end
endmodule

// File: rtl/nvm_wear.sv
module nvm_wear #(
   parameter int PI_W      = 4,
   parameter int CW        = 17,
   parameter int ENDURANCE = 100000,
   localparam int PAGES    = 1 << PI_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            inc_en,
   input  logic [PI_W-1:0] inc_page,
   input  logic [PI_W-1:0] chk_page,
   output logic            worn,
   input  logic [PI_W-1:0] rb_page,
   output logic [CW-1:0]   rb_cnt
);
   logic [CW-1:0] cnt [PAGES];

   for (genvar p = 0; p < PAGES; p++) begin : g_page
      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt[p] <= '0;
         else if (inc_en && inc_page == PI_W'(p) && cnt[p] != {CW{1'b1}})
            cnt[p] <= cnt[p] + 1'b1;
      end
   end

   assign worn   = cnt[chk_page] >= CW'(ENDURANCE);
   assign rb_cnt = cnt[rb_page];
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
   import nvm_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int PAGE_W    = 4,
   parameter int ERASE_CYC = 64,
   parameter int PROG_CYC  = 16,
   parameter int ENDURANCE = 100000,
   parameter int CNT_W     = 17,
   localparam int PI_W       = ADDR_W - PAGE_W,
   localparam int PAGE_BYTES = 1 << PAGE_W,
   localparam int LAT_MAX    = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
   localparam int TW         = $clog2(LAT_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        req_wdata,
   output logic              rd_valid,
   output logic [7:0]        rd_data,
   output logic              busy,
   output logic              done,
   output logic              erase_err,
   output logic              prog_err,
   output logic              overrun,
   input  logic [PI_W-1:0]   cnt_page,
   output logic [CNT_W-1:0]  cnt_value
);
   if (PAGE_W < 1 || PI_W < 1) begin : g_bad_geom
      $error("nvm_seq: need at least two pages of two bytes");
   end
   if (ERASE_CYC < 1 || PROG_CYC < 1) begin : g_bad_lat
      $error("nvm_seq: latencies must be at least one cycle");
   end
   if (ENDURANCE >= (64'd1 << CNT_W)) begin : g_bad_cnt
      $error("nvm_seq: CNT_W too narrow for ENDURANCE");
   end

   seq_state_t        st;
   logic [ADDR_W-1:0] a_q;
   logic [7:0]        d_q;
   logic [PAGE_W-1:0] idx;
   logic              bad;
   logic [PI_W-1:0]   page_q;
   logic [ADDR_W-1:0] arr_raddr;
   logic [7:0]        arr_rd;
   logic              bad_next, last_idx;
   logic              tmr_load, tmr_exp;
   logic [TW-1:0]     tmr_val;
   logic              worn, erase_en, prog_en;

   assign page_q   = a_q[ADDR_W-1:PAGE_W];
   assign bad_next = bad | (arr_rd != BLANK);
   assign last_idx = (idx == PAGE_W'(PAGE_BYTES - 1));

   always_comb begin
      unique case (st)
         S_IDLE:  arr_raddr = req_addr;
         S_VFYE:  arr_raddr = {page_q, idx};
         default: arr_raddr = a_q;
      endcase
   end

   assign tmr_load = (st == S_CHECK) || (st == S_VFYE && last_idx && !bad_next);
   assign tmr_val  = (st == S_CHECK && arr_rd != BLANK) ? TW'(ERASE_CYC - 1)
                                                         : TW'(PROG_CYC - 1);
   assign erase_en = (st == S_ERASE) && tmr_exp && !worn;
   assign prog_en  = (st == S_PROG) && tmr_exp && !worn;
   assign busy     = (st != S_IDLE);
   assign done     = (st == S_DONE);

   nvm_timer #(.TW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expire(tmr_exp)
   );

   nvm_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
      .clk(clk), .rst_n(rst_n), .rd_addr(arr_raddr), .rd_byte(arr_rd),
      .erase_en(erase_en), .erase_page(page_q),
      .prog_en(prog_en), .prog_addr(a_q), .prog_data(d_q)
   );

   nvm_wear #(.PI_W(PI_W), .CW(CNT_W), .ENDURANCE(ENDURANCE)) u_wear (
      .clk(clk), .rst_n(rst_n), .inc_en(done), .inc_page(page_q),
      .chk_page(page_q), .worn(worn), .rb_page(cnt_page), .rb_cnt(cnt_value)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         a_q       <= '0;
         d_q       <= '0;
         idx       <= '0;
         bad       <= 1'b0;
         rd_valid  <= 1'b0;
         rd_data   <= '0;
         erase_err <= 1'b0;
         prog_err  <= 1'b0;
         overrun   <= 1'b0;
      end else begin
         rd_valid <= 1'b0;
         if (st != S_IDLE && req_valid) overrun <= 1'b1;
         unique case (st)
            S_IDLE: if (req_valid) begin
               if (req_write) begin
                  a_q       <= req_addr;
                  d_q       <= req_wdata;
                  erase_err <= 1'b0;
                  prog_err  <= 1'b0;
                  st        <= S_CHECK;
               end else begin
                  rd_data  <= arr_rd;
                  rd_valid <= 1'b1;
               end
            end
            S_CHECK: st <= (arr_rd == BLANK) ? S_PROG : S_ERASE;
            S_ERASE: if (tmr_exp) begin
               st  <= S_VFYE;
               idx <= '0;
               bad <= 1'b0;
            end
            S_VFYE: begin
               bad <= bad_next;
               idx <= idx + 1'b1;
               if (last_idx) begin
                  if (bad_next) begin
                     erase_err <= 1'b1;
                     st        <= S_DONE;
                  end else begin
                     st <= S_PROG;
                  end
               end
            end
            S_PROG: if (tmr_exp) st <= S_VFYP;
            S_VFYP: begin
               if (arr_rd != d_q) prog_err <= 1'b1;
               st <= S_DONE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   // R6: the array must see a blank byte whenever a program pulse lands
   assert_prog_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
      prog_en |-> arr_rd == BLANK);

   // R5: done is a single cycle and busy drops right after it
   assert_done_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy && !done);

   assert_busy_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(done));

   // R7: erase failure only comes out of the page verify scan
   assert_erase_err_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(erase_err) |-> $past(st) == S_VFYE);

   // R9: overrun never clears without reset
   assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   // R2: read data only ever follows an idle cycle
   assert_read_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !$past(busy));
endmodule

// File: tb/nvm_seq_tb.sv
`timescale 1ns/1ps
module nvm_seq_tb;
   localparam int AW = 5, PW = 3, EC = 64, PC = 16, END = 3, CW = 8;
   localparam int SKIP = PC + 3;
   localparam int FULL = EC + 8 + PC + 3;
   localparam int EFAIL = EC + 8 + 2;

   typedef struct packed {
      logic [7:0] addr;
      logic [7:0] wdata;
      logic [7:0] cyc;
      logic       ee;
      logic       pe;
      logic [7:0] rdv;
   } vec_t;

   // page0 gets worn after three writes; entries 6 and 7 hit the worn page
   localparam vec_t VEC [8] = '{
      '{8'd0,  8'hA5, 8'(SKIP),  1'b0, 1'b0, 8'hA5},
      '{8'd1,  8'h3C, 8'(SKIP),  1'b0, 1'b0, 8'h3C},
      '{8'd0,  8'h5A, 8'(FULL),  1'b0, 1'b0, 8'h5A},
      '{8'd9,  8'hFF, 8'(SKIP),  1'b0, 1'b0, 8'hFF},
      '{8'd9,  8'h00, 8'(SKIP),  1'b0, 1'b0, 8'h00},
      '{8'd17, 8'h81, 8'(SKIP),  1'b0, 1'b0, 8'h81},
      '{8'd0,  8'h11, 8'(EFAIL), 1'b1, 1'b0, 8'h5A},
      '{8'd2,  8'h77, 8'(SKIP),  1'b0, 1'b1, 8'hFF}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0]    req_wdata = '0;
   logic          rd_valid, busy, done, erase_err, prog_err, overrun;
   logic [7:0]    rd_data;
   logic [AW-PW-1:0] cnt_page = '0;
   logic [CW-1:0] cnt_value;

   int errors = 0, checks = 0;

   always #2 clk = ~clk;

   nvm_seq #(.ADDR_W(AW), .PAGE_W(PW), .ERASE_CYC(EC), .PROG_CYC(PC),
             .ENDURANCE(END), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
      .rd_data(rd_data), .busy(busy), .done(done), .erase_err(erase_err),
      .prog_err(prog_err), .overrun(overrun), .cnt_page(cnt_page),
      .cnt_value(cnt_value)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic do_read(input logic [AW-1:0] a, output logic v, output logic [7:0] d);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      v = rd_valid; d = rd_data;
      @(negedge clk);
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d,
                           output int cyc, output int dn);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 0; dn = 0;
      while (busy && cyc < 2000) begin
         cyc++;
         if (done) dn++;
         @(negedge clk);
      end
   endtask

   task automatic chk_byte(input string tag, input logic [AW-1:0] a, input logic [7:0] e);
      logic v; logic [7:0] d;
      do_read(a, v, d);
      chk({tag, " rd_valid"}, 32'(v), 32'd1);
      chk({tag, " rd_data"}, 32'(d), 32'(e));
   endtask

   task automatic chk_cnt(input string tag, input int p, input int e);
      cnt_page = (AW-PW)'(p);
      #1;
      chk(tag, 32'(cnt_value), 32'(e));
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL R5 watchdog act=running exp=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int cyc, dn;
      logic v; logic [7:0] d;
      logic seen_rv;
      do_reset();

      // R1: reset state
      chk("R1 busy", 32'(busy), 0);
      chk("R1 done", 32'(done), 0);
      chk("R1 erase_err", 32'(erase_err), 0);
      chk("R1 prog_err", 32'(prog_err), 0);
      chk("R1 overrun", 32'(overrun), 0);
      chk("R1 rd_valid", 32'(rd_valid), 0);
      chk_byte("R1 blank byte", 5'd31, 8'hFF);
      for (int p = 0; p < 4; p++) chk_cnt("R1 counter", p, 0);

      // R3 R4 R7 R8 R11 R12 R5 R2: table walk
      for (int i = 0; i < 8; i++) begin
         do_write(VEC[i].addr[AW-1:0], VEC[i].wdata, cyc, dn);
         chk($sformatf("R3/R4/R7 busy len vec%0d", i), 32'(cyc), 32'(VEC[i].cyc));
         chk($sformatf("R5 done count vec%0d", i), 32'(dn), 1);
         chk($sformatf("R7/R12 erase_err vec%0d", i), 32'(erase_err), 32'(VEC[i].ee));
         chk($sformatf("R8/R12 prog_err vec%0d", i), 32'(prog_err), 32'(VEC[i].pe));
         chk_byte($sformatf("R2/R11 readback vec%0d", i), VEC[i].addr[AW-1:0], VEC[i].rdv);
      end

      // R4: neighbour in the erased page wiped, other pages kept
      chk_byte("R4 erased neighbour", 5'd1, 8'hFF);
      chk_byte("R4 other page", 5'd9, 8'h00);
      chk_byte("R4 other page2", 5'd17, 8'h81);
      // R3: skip path leaves neighbour bytes alone
      chk_byte("R3 untouched neighbour", 5'd18, 8'hFF);

      // R10: counters include error-ending sequences
      chk_cnt("R10 page0", 0, 5);
      chk_cnt("R10 page1", 1, 2);
      chk_cnt("R10 page2", 2, 1);
      chk_cnt("R10 page3", 3, 0);

      // R9: requests during busy
      req_valid = 1'b1; req_write = 1'b1; req_addr = 5'd24; req_wdata = 8'h42;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 5'd26; req_wdata = 8'h12;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 5'd24;
      @(negedge clk);
      req_valid = 1'b0;
      seen_rv = 1'b0;
      for (int k = 0; k < 2000 && busy; k++) begin
         if (rd_valid) seen_rv = 1'b1;
         @(negedge clk);
      end
      chk("R9 no read while busy", 32'(seen_rv), 0);
      chk("R9 overrun set", 32'(overrun), 1);
      chk_byte("R9 ignored write", 5'd26, 8'hFF);
      chk_byte("R9 accepted write", 5'd24, 8'h42);
      chk_cnt("R10 page3 one", 3, 1);
      do_write(5'd27, 8'h99, cyc, dn);
      chk("R9 overrun sticky", 32'(overrun), 1);
      do_read(5'd27, v, d);
      chk("R3 new byte", 32'(d), 32'h99);

      // R1: reset clears overrun and array
      do_reset();
      chk("R1 overrun cleared", 32'(overrun), 0);
      chk_byte("R1 array blank again", 5'd24, 8'hFF);
      chk_cnt("R1 counter cleared", 0, 0);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule